// File: doc/BRIEF.md
# Programmable Bus-Settling Delay Generator

This block times the settling interval of a talker on a parallel byte-wide instrument bus. It sits between the step that drives a byte onto the eight data lines and the step that raises the data-valid strobe. The source handshake logic pulses `start` when the byte is on the lines. The block counts a programmed number of clock cycles and then pulses `done`, which allows the strobe to be asserted.

The length of the interval scales with a 4-bit prescale value, `nf`. Software sets it to the clock frequency in MHz to get the nominal 2 µs, or sets it lower to get a faster transfer. Both the prescale and a high-speed enable are loaded through byte writes on a configuration port. High-speed mode is meant for tri-state line drivers. In that mode the full delay applies only to the first byte after the attention line goes from asserted to released. Every later byte uses a quarter of the full delay.

Top module: `settle_delay_gen`

## Requirements
- R1: After reset `done` is low, the prescale is 8 and high-speed mode is off, so the first start gives a 16-cycle delay.
- R2: A configuration write whose upper nibble is 0010 loads the low nibble as the prescale `nf`. In standard mode, `done` goes high exactly 2*nf clock edges after the edge that samples `start`.
- R3: A prescale write whose low nibble is 0 or greater than 8 is discarded, and the previous prescale stays in force.
- R4: A configuration write whose upper nibble is 1010 sets high-speed mode from bit 2 of the byte. A write with any other upper nibble (except 0010) changes neither the mode nor the prescale.
- R5: In high-speed mode, the first start sampled at or after a falling edge of `atn` uses the full 2*nf delay.
- R6: In high-speed mode, every later start uses ceil(nf/2) cycles, which is never below one cycle.
- R7: A start that arrives while a count is active is ignored. The running count neither restarts nor produces an extra `done`.
- R8: `done` is a single-cycle pulse. A start sampled in the cycle where `done` is high begins a new count.
- R9: A count uses the settings in force before the edge that samples its start. A configuration write sampled on that same edge affects only later counts.
- R10: Reset arms the first-byte state, so with high-speed mode on, the first start after reset uses the full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration byte write strobe |
| cfg_data | input | 8 | Configuration byte: upper nibble is the command code, low nibble is the value |
| atn | input | 1 | Attention line, high when asserted |
| start | input | 1 | Byte has been driven onto the data lines |
| done | output | 1 | One-cycle pulse: settling time has elapsed |

## Verification
There are two same-cycle collisions to check. The first is a new start landing in the cycle where `done` is high. The bench times it from the expected completion cycle of the previous byte and expects a second full-length count to begin at once. The second is a configuration write sampled on the same edge as a start. The bench drives both in one cycle and checks that this byte uses the old prescale and the following byte uses the new one. Each byte's expected `done` cycle is queued when the start is driven. Any pulse that arrives early, late or unrequested counts as a failure.

// File: rtl/settle_pkg.sv
package settle_pkg;

    localparam int CFG_W      = 8;
    localparam int CODE_W     = 4;
    localparam logic [CODE_W-1:0] CODE_PRESCALE = 4'b0010;
    localparam logic [CODE_W-1:0] CODE_MODE     = 4'b1010;
    localparam int MODE_HS_BIT = 2;

    typedef enum logic [1:0] {
        SEL_STANDARD = 2'd0,
        SEL_HS_LONG  = 2'd1,
        SEL_HS_SHORT = 2'd2
    } delay_sel_e;

endpackage

// File: rtl/settle_cfg.sv
module settle_cfg
    import settle_pkg::*;
#(
    parameter int NF_W   = 4,
    parameter int NF_MAX = 8,
    parameter int NF_RST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    output logic [NF_W-1:0]  nf_q,
    output logic             hs_q
);

    localparam int VAL_W = CFG_W - CODE_W;

    typedef struct packed {
        logic [NF_W-1:0] nf;
        logic            hs;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic [CODE_W-1:0] code;
    logic [VAL_W-1:0]  value;
    logic              nf_legal;

    assign code  = cfg_data[CFG_W-1 -: CODE_W];
    assign value = cfg_data[VAL_W-1:0];

    generate
        if (VAL_W > NF_W) begin : g_wide_val
            assign nf_legal = (value != '0) && (value <= VAL_W'(NF_MAX));
        end else begin : g_narrow_val
            assign nf_legal = (value != '0) && (NF_W'(value) <= NF_W'(NF_MAX));
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            if (code == CODE_PRESCALE && nf_legal) begin
                st_d.nf = NF_W'(value);
            end else if (code == CODE_MODE) begin
                st_d.hs = cfg_data[MODE_HS_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.nf <= NF_W'(NF_RST);
            st_q.hs <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign nf_q = st_q.nf;
    assign hs_q = st_q.hs;

    AST_NF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (nf_q != '0) && (nf_q <= NF_W'(NF_MAX))); // R3
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> $stable(nf_q) && $stable(hs_q)); // R4

endmodule

// File: rtl/settle_atn.sv
module settle_atn (
    input  logic clk,
    input  logic rst_n,
    input  logic atn,
    input  logic take,
    output logic use_long,
    output logic atn_fall
);

    typedef struct packed {
        logic atn_prev;
        logic first;
    } atn_state_t;

    atn_state_t st_d, st_q;

    assign atn_fall = st_q.atn_prev & ~atn;
    assign use_long = st_q.first | atn_fall;

    always_comb begin
        st_d          = st_q;
        st_d.atn_prev = atn;
        if (take) begin
            st_d.first = 1'b0;
        end else if (atn_fall) begin
            st_d.first = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.atn_prev <= 1'b0;
            st_q.first    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    AST_FIRST_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !st_q.first); // R6
    AST_FIRST_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        atn_fall && !take |=> st_q.first); // R5

endmodule

// File: rtl/settle_count.sv
module settle_count #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic             take,
    output logic             done
);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    assign take = start & ~st_q.busy;
    assign done = st_q.done;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.cnt  = len;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_LOAD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> st_q.busy && (st_q.cnt == $past(len))); // R2
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && (st_q.cnt > CNT_W'(1)) |=> st_q.busy && (st_q.cnt == $past(st_q.cnt) - CNT_W'(1))); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

endmodule

// File: rtl/settle_delay_gen.sv
module settle_delay_gen
    import settle_pkg::*;
#(
    parameter int NF_W   = 4,
    parameter int NF_MAX = 8,
    parameter int NF_RST = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             atn,
    input  logic             start,
    output logic             done
);

    localparam int CNT_W = $clog2(2 * NF_MAX + 1);

    logic [NF_W-1:0]  nf;
    logic             hs;
    logic             take;
    logic             use_long;
    logic             atn_fall;
    logic [CNT_W-1:0] len_full;
    logic [CNT_W-1:0] len_short;
    logic [CNT_W-1:0] len;
    delay_sel_e       sel;

    settle_cfg #(
        .NF_W  (NF_W),
        .NF_MAX(NF_MAX),
        .NF_RST(NF_RST)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .cfg_data(cfg_data),
        .nf_q    (nf),
        .hs_q    (hs)
    );

    settle_atn u_atn (
        .clk     (clk),
        .rst_n   (rst_n),
        .atn     (atn),
        .take    (take),
        .use_long(use_long),
        .atn_fall(atn_fall)
    );

    always_comb begin
        len_full  = CNT_W'(nf) << 1;
        len_short = (CNT_W'(nf) + CNT_W'(1)) >> 1;
        if (!hs) begin
            sel = SEL_STANDARD;
        end else if (use_long) begin
            sel = SEL_HS_LONG;
        end else begin
            sel = SEL_HS_SHORT;
        end
        case (sel)
            SEL_HS_SHORT: len = len_short;
            default:      len = len_full;
        endcase
    end

    settle_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .len  (len),
        .take (take),
        .done (done)
    );

    AST_SHORT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        take && (sel == SEL_HS_SHORT) |-> (len != '0) && (len <= len_full)); // R6
    AST_LONG_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        take && hs && atn_fall |-> (len == len_full)); // R5

endmodule

// File: tb/test_settle_delay_gen.sv
module test_settle_delay_gen;

    typedef struct {
        int    cyc;
        string req;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = 8'h00;
    logic       atn = 1'b0;
    logic       start = 1'b0;
    logic       done;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    int   ndone = 0;
    bit   finished = 1'b0;
    exp_t q[$];
    exp_t e;

    settle_delay_gen i_settle_delay_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_wr  (cfg_wr),
        .cfg_data(cfg_data),
        .atn     (atn),
        .start   (start),
        .done    (done)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares each done pulse against the queue head
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (q.size() != 0 && cyc == q[0].cyc) begin
                e = q.pop_front();
                total++;
                if (!done) begin
                    bad++;
                    $display("FAIL %s: done act=0 exp=1 at cycle %0d", e.req, cyc);
                end
            end else if (done) begin
                total++;
                bad++;
                $display("FAIL R7/R8: unexpected done act=1 exp=0 at cycle %0d", cyc);
            end
            if (done) ndone++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
        end
    endtask

    task automatic cfg_write(input logic [7:0] b);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_data = b;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic send(input int d, input string req);
        exp_t x;
        @(negedge clk);
        start = 1'b1;
        x.cyc = cyc + 1 + d;
        x.req = req;
        q.push_back(x);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic cfg_and_send(input logic [7:0] b, input int d, input string req);
        exp_t x;
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_data = b;
        start = 1'b1;
        x.cyc = cyc + 1 + d;
        x.req = req;
        q.push_back(x);
        @(negedge clk);
        cfg_wr = 1'b0;
        start = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic atn_pulse();
        @(negedge clk);
        atn = 1'b1;
        repeat (2) @(negedge clk);
        atn = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        int t;
        int n0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0, "R1", int'(done), 0);
        send(16, "R1");
        wait_idle();

        cfg_write(8'h23);
        send(6, "R2");
        wait_idle();
        cfg_write(8'h25);
        send(10, "R2");
        wait_idle();

        cfg_write(8'h20);
        send(10, "R3");
        wait_idle();
        cfg_write(8'h2C);
        send(10, "R3");
        wait_idle();

        cfg_write(8'h34);
        send(10, "R4");
        wait_idle();
        send(10, "R4");
        wait_idle();

        cfg_write(8'hA4);
        send(3, "R6");
        wait_idle();
        atn_pulse();
        send(10, "R5");
        wait_idle();
        send(3, "R6");
        wait_idle();

        cfg_write(8'h21);
        send(1, "R6");
        wait_idle();
        atn_pulse();
        send(2, "R5");
        wait_idle();
        send(1, "R6");
        wait_idle();
        cfg_write(8'hA0);
        send(2, "R4");
        wait_idle();

        // R7: extra start mid-count
        cfg_write(8'h24);
        n0 = ndone;
        send(8, "R7");
        repeat (2) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_idle();
        repeat (10) @(negedge clk);
        check(ndone - n0 == 1, "R7", ndone - n0, 1);

        // R8: new start in the done cycle
        send(8, "R8");
        t = q[q.size()-1].cyc;
        while (cyc < t) @(negedge clk);
        begin
            exp_t x;
            start = 1'b1;
            x.cyc = cyc + 1 + 8;
            x.req = "R8";
            q.push_back(x);
            @(negedge clk);
            start = 1'b0;
        end
        wait_idle();

        // R9: write and start on the same edge
        cfg_and_send(8'h22, 8, "R9");
        wait_idle();
        send(4, "R9");
        wait_idle();

        // R10: first byte after reset is long in high-speed mode
        do_reset();
        check(done == 1'b0, "R1", int'(done), 0);
        cfg_write(8'h24);
        cfg_write(8'hA4);
        send(8, "R10");
        wait_idle();
        send(2, "R6");
        wait_idle();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL all: watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule